// File: doc/BRIEF.md
# True Dual-Port Byte-Write RAM

This block is a behavioural, synthesizable memory of 4096 words of 32 bits with two independent ports, A and B. Each port has its own clock, its own active-low synchronous reset, an enable, a 4-bit byte-lane write mask, a 12-bit word address, write data and read data. Either port may read or write in any cycle, so the block can serve two reads, two writes or one of each at the same time.

A port is idle when its enable is low. With the enable high, a write mask of zero reads the addressed word and any set mask bit writes the selected lanes. Read data passes through a capture stage and then an output register that is clocked every cycle. The word therefore appears two clocks after the address and stays steady for a full period. The array powers up holding a fixed set of nonzero words. Software uses byte offsets, and the word index is the offset divided by four.

When both ports run from one clock, collisions follow fixed rules. If both ports write the same word, port B takes the byte lanes they share, and the lanes only one port writes are all stored. A read of a word that the other port writes in the same cycle returns the old contents.

Top module: `tdp_bytewrite_ram`

## Requirements
- R1: Ports A and B work in the same cycle without interfering: two reads, two writes, or a read on one port and a write on the other.
- R2: With its enable low, a port neither reads nor writes, whatever its write mask holds: its read data keeps its value and the array is unchanged.
- R3: With the enable high, a write mask of 4'b0000 performs a read and any nonzero mask performs a write.
- R4: Write mask bit i (i = 0..3) writes bits [8i+7:8i] of the word, and the lanes whose bits are clear keep their old bytes.
- R5: A read whose address is sampled at clock edge k drives the word on the read data output after edge k+1, and the value holds until a later read replaces it.
- R6: A write cycle does not load the read path, so the port's read data keeps its previous value.
- R7: The 12-bit word address reaches all 4096 words, including word 4095. Word index = byte offset / 4.
- R8: At power-up word 0 = 0x00002597, word 1 = 0x00006425, word 7 = 0x00005071 and word 16 = 0x00008CF5. Words 2 to 6 are zero.
- R9: At power-up words 8 to 15 and words 17 to 23 hold 0x08040201, and every other word not named in R8 holds zero.
- R10: On a shared clock, when both ports write the same word in the same cycle, port B's bytes win on the lanes both masks select, and the lanes selected by only one mask are all written.
- R11: On a shared clock, a read of a word that the other port writes in the same cycle returns the contents from before that write.
- R12: Holding a port's reset low for a clock edge clears that port's read data to zero. It leaves the array and the other port's read data unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| rst_n_a | input | 1 | Port A synchronous active-low reset of the read path |
| en_a | input | 1 | Port A enable |
| we_a | input | 4 | Port A byte-lane write mask |
| addr_a | input | 12 | Port A word address |
| wdata_a | input | 32 | Port A write data |
| rdata_a | output | 32 | Port A read data |
| clk_b | input | 1 | Port B clock |
| rst_n_b | input | 1 | Port B synchronous active-low reset of the read path |
| en_b | input | 1 | Port B enable |
| we_b | input | 4 | Port B byte-lane write mask |
| addr_b | input | 12 | Port B word address |
| wdata_b | input | 32 | Port B write data |
| rdata_b | output | 32 | Port B read data |

## Verification
Every request the bench drives is sampled at the following rising edge. Its effect on the read data is due one edge after that, so the scoreboard stamps each expected item with the current cycle count plus two and compares it at the falling edge of that cycle. Idle and write cycles queue the port's previous value as their expected item, which checks R2 and R6 on the same two-cycle schedule. Reset effects are checked directly at the falling edge after the reset edge, once the queues have drained. The bench drives both ports from one clock, which gives the collision cases of R10 and R11 a defined cycle.

// File: rtl/tdp_pkg.sv
// Package: shared constants and the power-up image of the dual-port RAM.
// Assumes 32-bit words; the top module resizes the image to its own width.
package tdp_pkg;

    localparam logic [31:0] FILL_PATTERN = 32'h0804_0201;

    // Compute the power-up word stored at a given word index.
    function automatic logic [31:0] preset_word(input int unsigned idx);
        logic [31:0] val;
        val = '0;
        if (idx == 0)                       val = 32'h0000_2597;
        else if (idx == 1)                  val = 32'h0000_6425;
        else if (idx == 7)                  val = 32'h0000_5071;
        else if (idx == 16)                 val = 32'h0000_8CF5;
        else if (idx >= 8 && idx <= 15)     val = FILL_PATTERN;
        else if (idx >= 17 && idx <= 23)    val = FILL_PATTERN;
        return val;
    endfunction

endpackage

// File: rtl/tdp_write_gate.sv
// Module: tdp_write_gate
// Resolves same-word write collisions by removing port A's claim on any
// lane that port B also writes. Assumes both ports share a clock when
// SHARED_CLK is 1; with SHARED_CLK 0 the masks pass through untouched.
module tdp_write_gate #(
    parameter int ADDR_W     = 12,
    parameter int LANES      = 4,
    parameter bit SHARED_CLK = 1'b1
) (
    input  logic [LANES-1:0]  wr_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [LANES-1:0]  wr_b,
    input  logic [ADDR_W-1:0] addr_b,
    output logic [LANES-1:0]  wr_a_eff
);

    generate
        if (SHARED_CLK) begin : g_shared
            // Drop port A lanes that port B overwrites in the same cycle.
            always_comb begin
                wr_a_eff = wr_a;
                if (addr_a == addr_b) begin
                    wr_a_eff = wr_a & ~wr_b;
                end
            end
        end else begin : g_indep
            // Unrelated clocks: no same-cycle arbitration is possible.
            always_comb wr_a_eff = wr_a;
        end
    endgenerate

endmodule

// File: rtl/tdp_read_pipe.sv
// Module: tdp_read_pipe
// Two-stage read path: a capture stage loaded on read cycles and an
// output register clocked every cycle. Assumes din is the array word for
// the address presented in the same cycle.
module tdp_read_pipe #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] cap_q;
    logic [DATA_W-1:0] out_q;

    // Capture on reads, hold otherwise; output stage always advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
            out_q <= '0;
        end else begin
            if (load) begin
                cap_q <= din;
            end
            out_q <= cap_q;
        end
    end

    assign dout = out_q;

endmodule

// File: rtl/tdp_bytewrite_ram.sv
// Module: tdp_bytewrite_ram
// True dual-port RAM with byte-lane writes and a registered read path.
// Each port owns one storage bank plus a per-lane ownership bit. A lane's
// live data sits in bank A when both ownership bits match, else in bank B.
// That keeps each array written from exactly one clock domain. Collision
// rules (B wins shared lanes, reads return old data) assume a shared clock.
module tdp_bytewrite_ram #(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int LANE_W     = 8,
    parameter bit SHARED_CLK = 1'b1
) (
    input  logic              clk_a,
    input  logic              rst_n_a,
    input  logic              en_a,
    input  logic [3:0]        we_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [DATA_W-1:0] wdata_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic              clk_b,
    input  logic              rst_n_b,
    input  logic              en_b,
    input  logic [3:0]        we_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [DATA_W-1:0] wdata_b,
    output logic [DATA_W-1:0] rdata_b
);

    localparam int WORDS = 1 << ADDR_W;
    localparam int LANES = DATA_W / LANE_W;

    logic [DATA_W-1:0] bank_a [WORDS];
    logic [DATA_W-1:0] bank_b [WORDS];
    logic [LANES-1:0]  own_a  [WORDS];
    logic [LANES-1:0]  own_b  [WORDS];

    logic [LANES-1:0]  wr_a;
    logic [LANES-1:0]  wr_b;
    logic [LANES-1:0]  wr_a_eff;
    logic [DATA_W-1:0] rd_word_a;
    logic [DATA_W-1:0] rd_word_b;
    logic              rd_a;
    logic              rd_b;

    // Load the power-up image into bank A, which owns every lane at start.
    initial begin
        for (int i = 0; i < WORDS; i++) begin
            bank_a[i] = DATA_W'(tdp_pkg::preset_word(i));
            bank_b[i] = '0;
            own_a[i]  = '0;
            own_b[i]  = '0;
        end
    end

    // Decode enable and mask into per-lane write strobes and read flags.
    always_comb begin
        wr_a = en_a ? we_a[LANES-1:0] : '0;
        wr_b = en_b ? we_b[LANES-1:0] : '0;
        rd_a = en_a && (we_a == 4'b0000);
        rd_b = en_b && (we_b == 4'b0000);
    end

    tdp_write_gate #(
        .ADDR_W     (ADDR_W),
        .LANES      (LANES),
        .SHARED_CLK (SHARED_CLK)
    ) u_gate (
        .wr_a     (wr_a),
        .addr_a   (addr_a),
        .wr_b     (wr_b),
        .addr_b   (addr_b),
        .wr_a_eff (wr_a_eff)
    );

    // Port A write: store bytes in bank A and claim the written lanes.
    always_ff @(posedge clk_a) begin
        for (int l = 0; l < LANES; l++) begin
            if (wr_a_eff[l]) begin
                bank_a[addr_a][l*LANE_W +: LANE_W] <= wdata_a[l*LANE_W +: LANE_W];
                own_a[addr_a][l] <= own_b[addr_a][l];
            end
        end
    end

    // Port B write: store bytes in bank B and claim the written lanes.
    always_ff @(posedge clk_b) begin
        for (int l = 0; l < LANES; l++) begin
            if (wr_b[l]) begin
                bank_b[addr_b][l*LANE_W +: LANE_W] <= wdata_b[l*LANE_W +: LANE_W];
                own_b[addr_b][l] <= ~own_a[addr_b][l];
            end
        end
    end

    // Assemble the live word for port A lane by lane from the owning bank.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            rd_word_a[l*LANE_W +: LANE_W] =
                (own_a[addr_a][l] == own_b[addr_a][l]) ?
                bank_a[addr_a][l*LANE_W +: LANE_W] :
                bank_b[addr_a][l*LANE_W +: LANE_W];
        end
    end

    // Assemble the live word for port B lane by lane from the owning bank.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            rd_word_b[l*LANE_W +: LANE_W] =
                (own_a[addr_b][l] == own_b[addr_b][l]) ?
                bank_a[addr_b][l*LANE_W +: LANE_W] :
                bank_b[addr_b][l*LANE_W +: LANE_W];
        end
    end

    tdp_read_pipe #(.DATA_W(DATA_W)) u_pipe_a (
        .clk   (clk_a),
        .rst_n (rst_n_a),
        .load  (rd_a),
        .din   (rd_word_a),
        .dout  (rdata_a)
    );

    tdp_read_pipe #(.DATA_W(DATA_W)) u_pipe_b (
        .clk   (clk_b),
        .rst_n (rst_n_b),
        .load  (rd_b),
        .din   (rd_word_b),
        .dout  (rdata_b)
    );

endmodule

// File: rtl/tdp_bytewrite_ram_chk.sv
// Module: tdp_bytewrite_ram_chk
// Temporal checks on each port's read path, bound into the RAM top.
// Assumes the live array word for each port's address is visible.
module tdp_bytewrite_ram_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk_a,
    input logic              rst_n_a,
    input logic              en_a,
    input logic [3:0]        we_a,
    input logic [DATA_W-1:0] rdata_a,
    input logic [DATA_W-1:0] rd_word_a,
    input logic              clk_b,
    input logic              rst_n_b,
    input logic              en_b,
    input logic [3:0]        we_b,
    input logic [DATA_W-1:0] rdata_b,
    input logic [DATA_W-1:0] rd_word_b
);

    AST_RST_CLEARS_A: assert property (@(posedge clk_a)
        $past(!rst_n_a) |-> rdata_a == '0);                                   // R12
    AST_RST_CLEARS_B: assert property (@(posedge clk_b)
        $past(!rst_n_b) |-> rdata_b == '0);                                   // R12
    AST_READ_LATENCY_A: assert property (@(posedge clk_a) disable iff (!rst_n_a)
        ($past(rst_n_a) && $past(rst_n_a, 2) && $past(en_a && we_a == 4'b0000, 2))
        |-> rdata_a == $past(rd_word_a, 2));                                  // R5
    AST_READ_LATENCY_B: assert property (@(posedge clk_b) disable iff (!rst_n_b)
        ($past(rst_n_b) && $past(rst_n_b, 2) && $past(en_b && we_b == 4'b0000, 2))
        |-> rdata_b == $past(rd_word_b, 2));                                  // R5
    AST_IDLE_HOLD_A: assert property (@(posedge clk_a) disable iff (!rst_n_a)
        ($past(rst_n_a) && $past(rst_n_a, 2) && $past(!en_a, 2))
        |-> $stable(rdata_a));                                                // R2
    AST_IDLE_HOLD_B: assert property (@(posedge clk_b) disable iff (!rst_n_b)
        ($past(rst_n_b) && $past(rst_n_b, 2) && $past(!en_b, 2))
        |-> $stable(rdata_b));                                                // R2
    AST_WRITE_HOLD_A: assert property (@(posedge clk_a) disable iff (!rst_n_a)
        ($past(rst_n_a) && $past(rst_n_a, 2) && $past(en_a && we_a != 4'b0000, 2))
        |-> $stable(rdata_a));                                                // R6
    AST_WRITE_HOLD_B: assert property (@(posedge clk_b) disable iff (!rst_n_b)
        ($past(rst_n_b) && $past(rst_n_b, 2) && $past(en_b && we_b != 4'b0000, 2))
        |-> $stable(rdata_b));                                                // R6

endmodule

bind tdp_bytewrite_ram tdp_bytewrite_ram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_a     (clk_a),
    .rst_n_a   (rst_n_a),
    .en_a      (en_a),
    .we_a      (we_a),
    .rdata_a   (rdata_a),
    .rd_word_a (rd_word_a),
    .clk_b     (clk_b),
    .rst_n_b   (rst_n_b),
    .en_b      (en_b),
    .we_b      (we_b),
    .rdata_b   (rdata_b),
    .rd_word_b (rd_word_b)
);

// File: tb/tdp_bytewrite_ram_tb.sv
// Scoreboard bench: the driver task queues expected read data per port,
// stamped with the cycle it is due; a monitor compares at falling edges.
module tdp_bytewrite_ram_tb;

    typedef struct {
        int          due;
        logic [31:0] val;
        string       tag;
    } exp_t;

    logic        clk;
    logic        rst_n_a, rst_n_b;
    logic        en_a, en_b;
    logic [3:0]  we_a, we_b;
    logic [11:0] addr_a, addr_b;
    logic [31:0] wdata_a, wdata_b;
    logic [31:0] rdata_a, rdata_b;

    int          cyc = 0;
    int          total = 0;
    int          bad = 0;
    exp_t        qa[$];
    exp_t        qb[$];
    logic [31:0] model [4096];
    logic [31:0] last_a, last_b;

    tdp_bytewrite_ram u_dut (
        .clk_a(clk), .rst_n_a(rst_n_a), .en_a(en_a), .we_a(we_a),
        .addr_a(addr_a), .wdata_a(wdata_a), .rdata_a(rdata_a),
        .clk_b(clk), .rst_n_b(rst_n_b), .en_b(en_b), .we_b(we_b),
        .addr_b(addr_b), .wdata_b(wdata_b), .rdata_b(rdata_b)
    );

    initial clk = 1'b0;
    always #10ns clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Power-up image written from R8 and R9.
    function automatic logic [31:0] power_up(input int i);
        case (i)
            0:  return 32'h0000_2597;
            1:  return 32'h0000_6425;
            7:  return 32'h0000_5071;
            16: return 32'h0000_8CF5;
            default: return ((i >= 8 && i <= 15) || (i >= 17 && i <= 23)) ? 32'h0804_0201 : 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Monitor: compare every item whose due cycle has arrived.
    always @(negedge clk) begin
        while (qa.size() > 0 && qa[0].due == cyc) begin
            check({qa[0].tag, " port A"}, rdata_a, qa[0].val);
            void'(qa.pop_front());
        end
        while (qb.size() > 0 && qb[0].due == cyc) begin
            check({qb[0].tag, " port B"}, rdata_b, qb[0].val);
            void'(qb.pop_front());
        end
    end

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d, input logic [3:0] m);
        logic [31:0] r = old;
        for (int l = 0; l < 4; l++) if (m[l]) r[l*8 +: 8] = d[l*8 +: 8];
        return r;
    endfunction

    // Driver: one shared-clock cycle on both ports, with expected results.
    task automatic op(input logic ea, input logic [3:0] wa, input int ada, input logic [31:0] da,
                      input logic eb, input logic [3:0] wb, input int adb, input logic [31:0] db,
                      input string tag);
        exp_t e;
        @(negedge clk);
        en_a = ea; we_a = wa; addr_a = 12'(ada); wdata_a = da;
        en_b = eb; we_b = wb; addr_b = 12'(adb); wdata_b = db;
        if (ea && wa == 4'b0000) last_a = model[ada];
        if (eb && wb == 4'b0000) last_b = model[adb];
        e.due = cyc + 2;
        e.val = last_a;
        e.tag = !ea ? "R2 idle hold" : (wa != 0 ? "R6 write hold" : {"R5 ", tag});
        qa.push_back(e);
        e.val = last_b;
        e.tag = !eb ? "R2 idle hold" : (wb != 0 ? "R6 write hold" : {"R5 ", tag});
        qb.push_back(e);
        if (ea && wa != 0) model[ada] = merge(model[ada], da, wa);
        if (eb && wb != 0) model[adb] = merge(model[adb], db, wb);
    endtask

    task automatic drain();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            en_a = 1'b0; we_a = 4'hF; en_b = 1'b0; we_b = 4'hF;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) model[i] = power_up(i);
        rst_n_a = 1'b0; rst_n_b = 1'b0;
        en_a = 1'b0; en_b = 1'b0; we_a = '0; we_b = '0;
        addr_a = '0; addr_b = '0; wdata_a = '0; wdata_b = '0;
        last_a = '0; last_b = '0;
        repeat (3) @(negedge clk);
        rst_n_a = 1'b1; rst_n_b = 1'b1;
        check("R12 reset A", rdata_a, 32'h0);
        check("R12 reset B", rdata_b, 32'h0);

        // R8/R9 power-up image through dual reads (R1, R3).
        op(1, 4'h0, 0,    0, 1, 4'h0, 1,    0, "R8 R1 word0/1");
        op(1, 4'h0, 7,    0, 1, 4'h0, 16,   0, "R8 word7/16");
        op(1, 4'h0, 8,    0, 1, 4'h0, 23,   0, "R9 fill ends");
        op(1, 4'h0, 2,    0, 1, 4'h0, 24,   0, "R9 zero words");
        op(1, 4'h0, 15,   0, 1, 4'h0, 17,   0, "R9 fill edges");
        op(1, 4'h0, 4095, 0, 1, 4'h0, 6,    0, "R9 R7 top zero");
        // R1 dual write, then cross reads (R3).
        op(1, 4'hF, 100, 32'hDEAD_BEEF, 1, 4'hF, 200, 32'h1234_5678, "R1 dual write");
        op(1, 4'h0, 200, 0, 1, 4'h0, 100, 0, "R1 R3 cross read");
        // R4 byte lanes.
        op(1, 4'b0001, 0, 32'hAAAA_AA11, 1, 4'b1010, 1, 32'hBBCC_DDEE, "R4 lanes");
        op(1, 4'h0, 1, 0, 1, 4'h0, 0, 0, "R4 lane readback");
        // R2 disabled port with mask set must not write.
        op(0, 4'hF, 0, 32'hFFFF_FFFF, 0, 4'hF, 1, 32'hFFFF_FFFF, "R2 disabled");
        op(0, 4'h0, 0, 0, 0, 4'h0, 0, 0, "R2 idle");
        op(1, 4'h0, 0, 0, 1, 4'h0, 1, 0, "R2 no write");
        // R7 top word written by A, read by B.
        op(1, 4'hF, 4095, 32'hCAFE_F00D, 0, 4'h0, 0, 0, "R7 write top");
        op(0, 4'h0, 0, 0, 1, 4'h0, 4095, 0, "R7 read top");
        // R10 write-write collision on a shared clock.
        op(1, 4'hF, 300, 32'h1111_1111, 1, 4'b0011, 300, 32'h2222_2222, "R10 collide");
        op(1, 4'h0, 300, 0, 1, 4'h0, 300, 0, "R10 merged");
        op(1, 4'b1100, 301, 32'h4444_4444, 1, 4'b0011, 301, 32'h5555_5555, "R10 disjoint");
        op(1, 4'h0, 301, 0, 0, 4'h0, 0, 0, "R10 disjoint read");
        // R11 read during the other port's write returns old data.
        op(1, 4'h0, 300, 0, 1, 4'hF, 300, 32'h3333_3333, "R11 old data");
        op(1, 4'h0, 300, 0, 1, 4'hF, 302, 32'h7777_7777, "R11 new data");
        op(1, 4'hF, 302, 32'h8888_8888, 1, 4'h0, 302, 0, "R11 B reads old");
        op(0, 4'h0, 0, 0, 1, 4'h0, 302, 0, "R11 B reads new");

        // R12 reset of port A only.
        drain();
        @(negedge clk);
        rst_n_a = 1'b0;
        @(negedge clk);
        rst_n_a = 1'b1;
        check("R12 A cleared", rdata_a, 32'h0);
        check("R12 B untouched", rdata_b, last_b);
        last_a = '0;
        op(1, 4'h0, 300, 0, 0, 4'h0, 0, 0, "R12 array kept");
        op(1, 4'h0, 4095, 0, 1, 4'h0, 0, 0, "R12 array kept");
        drain();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule